// File: doc/BRIEF.md
# Direct-Mapped Branch Target Buffer

This block is a direct-mapped table of predicted branch targets, indexed by the fetch address. Each accepted lookup returns, one cycle later, whether a live entry matches the address, the stored target and a taken hint taken from a two-bit saturating counter. Resolved branches train or replace entries through an update port. That port can also kill an entry that predicted for an instruction that turned out not to be a branch. Entries hold effective addresses, so a task-switch pulse drops every entry at once.

Each miss is classified. A miss is cold when its slot has never been written since reset. It is a replacement miss when the slot was written at some point, even if that entry was later killed, displaced or flushed. Three counters keep the totals of hits, cold misses and replacement misses.

Lookups use a valid/ready pair. A request is accepted when `lk_valid` and `lk_ready` are both high. The answer is held in one output register with `rsp_valid`/`rsp_ready`. `lk_ready` is high whenever that register is empty or is being drained in the same cycle, so a stalled consumer stops new lookups and nothing else. The update port and the task-switch input are always accepted.

Top module: `branch_target_buffer`

## Requirements
- R1: After reset `rsp_valid` is 0, `lk_ready` is 1, all three counters read 0, no entry is live and no slot has ever been written.
- R2: The slot is address bits [7:2] (64 slots). The tag is bits [31:8]. A lookup hits only when its slot holds a live entry with an equal tag.
- R3: An accepted lookup produces its response in the next cycle. It sees the table as it was before any update or task switch in the same cycle.
- R4: On a hit, `rsp_target` is the stored target and `rsp_taken` is bit 1 of the entry counter. On a miss both are 0.
- R5: A non-kill update whose address has no live matching entry allocates the slot. It writes the tag and the target, and sets the counter to 2 when `upd_taken` is 1 or to 1 when it is 0. Any other entry in that slot is replaced.
- R6: A non-kill update that matches a live entry replaces its target. It raises the counter by one if taken or lowers it by one if not, saturating at 3 and 0.
- R7: A kill update (`upd_kill`=1) makes a matching live entry not live. A kill whose tag does not match changes nothing.
- R8: A `task_switch` pulse makes every entry not live in one cycle. An update in the same cycle is applied after that clear, so it always allocates.
- R9: `rsp_cold` is 1 on a miss to a slot never written since reset and 0 otherwise. Kills and task switches do not reset the written history.
- R10: At each accepted lookup exactly one of `hit_count`, `cold_miss_count` or `repl_miss_count` rises by one, visible the next cycle. The counters wrap.
- R11: `lk_ready` = !`rsp_valid` || `rsp_ready`. While `rsp_valid` is 1 and `rsp_ready` is 0, all response outputs hold. `rsp_valid` falls after a drain with no new lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request present |
| lk_ready | output | 1 | Lookup can be accepted |
| lk_pc | input | 32 | Fetch address to look up |
| rsp_valid | output | 1 | Response register full |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_hit | output | 1 | Live matching entry found |
| rsp_cold | output | 1 | Miss on a never-written slot |
| rsp_taken | output | 1 | Taken hint of the hit entry |
| rsp_target | output | 32 | Predicted target on hit |
| upd_valid | input | 1 | Update request this cycle |
| upd_pc | input | 32 | Address of the resolved instruction |
| upd_target | input | 32 | Resolved target |
| upd_taken | input | 1 | Resolved direction |
| upd_kill | input | 1 | Drop the matching entry instead |
| task_switch | input | 1 | Flush all entries |
| hit_count | output | 16 | Number of hits |
| cold_miss_count | output | 16 | Number of cold misses |
| repl_miss_count | output | 16 | Number of replacement misses |

## Verification
Random traffic uses sixteen slots and four tags. This gives many tag conflicts in each slot, so tag compare, allocation over a live entry, and matched training are all exercised. Directed sequences cover the remaining corner cases:
- A first lookup against a second lookup after the slot is displaced, killed or flushed. This separates cold misses from replacement misses.
- Long runs of same-direction updates. These reach both counter limits.
- A task switch paired with an update in the same cycle.
- A lookup in the same cycle as an update to its own slot. This shows the read-before-write order.
- Random holds of `rsp_ready`. These show that the response stays frozen and that `lk_ready` follows the register state.

// File: rtl/btb_pkg.sv
package btb_pkg;

  typedef logic [1:0] pred_ctr_t;

  localparam pred_ctr_t CTR_MAX = 2'd3;
  localparam pred_ctr_t CTR_MIN = 2'd0;

  // training step of the two-bit saturating counter
  function automatic pred_ctr_t ctr_train(input pred_ctr_t c, input logic taken);
    pred_ctr_t r;
    if (taken) r = (c == CTR_MAX) ? c : c + 2'd1;
    else       r = (c == CTR_MIN) ? c : c - 2'd1;
    return r;
  endfunction

  // initial counter value on allocation: weakly biased toward outcome
  function automatic pred_ctr_t ctr_seed(input logic taken);
    return taken ? 2'd2 : 2'd1;
  endfunction

  typedef enum logic [1:0] {
    LK_HIT  = 2'd0,
    LK_COLD = 2'd1,
    LK_REPL = 2'd2
  } lookup_kind_e;

endpackage

// File: rtl/btb_addr_split.sv
module btb_addr_split #(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 6,
  parameter int IDX_LSB = 2,
  localparam int TAG_W  = ADDR_W - IDX_W - IDX_LSB
) (
  input  logic [ADDR_W-1:0] pc,
  output logic [IDX_W-1:0]  idx,
  output logic [TAG_W-1:0]  tag
);

  logic unused_low_bits;

  assign idx = pc[IDX_LSB +: IDX_W];
  assign tag = pc[ADDR_W-1 -: TAG_W];
  assign unused_low_bits = ^pc[IDX_LSB-1:0];

endmodule

// File: rtl/btb_store.sv
module btb_store
  import btb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 6,
  parameter int IDX_LSB = 2,
  localparam int TAG_W  = ADDR_W - IDX_W - IDX_LSB,
  localparam int ENTRIES = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  // read side (combinational, pre-edge contents)
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_live,
  output logic              rd_written,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [ADDR_W-1:0] rd_target,
  output pred_ctr_t         rd_ctr,
  // write side
  input  logic              upd_valid,
  input  logic [IDX_W-1:0]  upd_idx,
  input  logic [TAG_W-1:0]  upd_tag,
  input  logic [ADDR_W-1:0] upd_target,
  input  logic              upd_taken,
  input  logic              upd_kill,
  input  logic              flush
);

  logic [ENTRIES-1:0] live_q;
  logic [ENTRIES-1:0] written_q;
  logic [TAG_W-1:0]   tag_q    [ENTRIES];
  logic [ADDR_W-1:0]  target_q [ENTRIES];
  pred_ctr_t          ctr_q    [ENTRIES];

  logic               upd_match;
  logic               data_we;
  logic               tag_we;
  pred_ctr_t          ctr_wdata;
  logic [ENTRIES-1:0] set_sel;
  logic [ENTRIES-1:0] clr_sel;

  // a flush in the same cycle hides every entry from the update
  assign upd_match = upd_valid && !flush && live_q[upd_idx] &&
                     (tag_q[upd_idx] == upd_tag);

  assign data_we   = upd_valid && !upd_kill;
  assign tag_we    = data_we && !upd_match;
  assign ctr_wdata = upd_match ? ctr_train(ctr_q[upd_idx], upd_taken)
                               : ctr_seed(upd_taken);

  for (genvar e = 0; e < ENTRIES; e++) begin : g_sel
    assign set_sel[e] = data_we && (upd_idx == IDX_W'(e));
    assign clr_sel[e] = upd_kill && upd_match && (upd_idx == IDX_W'(e));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      live_q    <= '0;
      written_q <= '0;
    end else begin
      live_q    <= ((flush ? '0 : live_q) & ~clr_sel) | set_sel;
      written_q <= written_q | set_sel;
    end
  end

  always_ff @(posedge clk) begin
    if (data_we) begin
      target_q[upd_idx] <= upd_target;
      ctr_q[upd_idx]    <= ctr_wdata;
    end
    if (tag_we) begin
      tag_q[upd_idx] <= upd_tag;
    end
  end

  assign rd_live    = live_q[rd_idx];
  assign rd_written = written_q[rd_idx];
  assign rd_tag     = tag_q[rd_idx];
  assign rd_target  = target_q[rd_idx];
  assign rd_ctr     = ctr_q[rd_idx];

  // written history only ever grows
  assert_written_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(written_q) & ~written_q) == '0));

  // a live slot has always been written
  assert_live_implies_written_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((live_q & ~written_q) == '0));

  // after a flush without an update, nothing is live
  assert_flush_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flush && !upd_valid) |=> (live_q == '0));

endmodule

// File: rtl/btb_stats.sv
module btb_stats
  import btb_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  lookup_kind_e     kind,
  output logic [CNT_W-1:0] hit_count,
  output logic [CNT_W-1:0] cold_count,
  output logic [CNT_W-1:0] repl_count
);

  logic [CNT_W-1:0] total;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_count  <= '0;
      cold_count <= '0;
      repl_count <= '0;
    end else if (fire) begin
      unique case (kind)
        LK_HIT:  hit_count  <= hit_count  + 1'b1;
        LK_COLD: cold_count <= cold_count + 1'b1;
        default: repl_count <= repl_count + 1'b1;
      endcase
    end
  end

  assign total = hit_count + cold_count + repl_count;

  assert_one_count_per_lookup_R10: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (total == $past(total) + CNT_W'($past(fire))));

endmodule

// File: rtl/branch_target_buffer.sv
module branch_target_buffer
  import btb_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int IDX_W   = 6,
  parameter int IDX_LSB = 2,
  parameter int CNT_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [ADDR_W-1:0] lk_pc,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic              rsp_hit,
  output logic              rsp_cold,
  output logic              rsp_taken,
  output logic [ADDR_W-1:0] rsp_target,
  input  logic              upd_valid,
  input  logic [ADDR_W-1:0] upd_pc,
  input  logic [ADDR_W-1:0] upd_target,
  input  logic              upd_taken,
  input  logic              upd_kill,
  input  logic              task_switch,
  output logic [CNT_W-1:0]  hit_count,
  output logic [CNT_W-1:0]  cold_miss_count,
  output logic [CNT_W-1:0]  repl_miss_count
);

  localparam int TAG_W = ADDR_W - IDX_W - IDX_LSB;

  logic [IDX_W-1:0]  lk_idx, up_idx;
  logic [TAG_W-1:0]  lk_tag, up_tag;
  logic              rd_live, rd_written;
  logic [TAG_W-1:0]  rd_tag;
  logic [ADDR_W-1:0] rd_target;
  pred_ctr_t         rd_ctr;
  logic              lk_fire;
  logic              lk_hit;
  lookup_kind_e      lk_kind;

  btb_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB)) i_split_lk (
    .pc(lk_pc), .idx(lk_idx), .tag(lk_tag)
  );

  btb_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB)) i_split_up (
    .pc(upd_pc), .idx(up_idx), .tag(up_tag)
  );

  btb_store #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB)) i_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_idx     (lk_idx),
    .rd_live    (rd_live),
    .rd_written (rd_written),
    .rd_tag     (rd_tag),
    .rd_target  (rd_target),
    .rd_ctr     (rd_ctr),
    .upd_valid  (upd_valid),
    .upd_idx    (up_idx),
    .upd_tag    (up_tag),
    .upd_target (upd_target),
    .upd_taken  (upd_taken),
    .upd_kill   (upd_kill),
    .flush      (task_switch)
  );

  assign lk_ready = !rsp_valid || rsp_ready;
  assign lk_fire  = lk_valid && lk_ready;
  assign lk_hit   = rd_live && (rd_tag == lk_tag);

  always_comb begin
    if (lk_hit)          lk_kind = LK_HIT;
    else if (rd_written) lk_kind = LK_REPL;
    else                 lk_kind = LK_COLD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_cold   <= 1'b0;
      rsp_taken  <= 1'b0;
      rsp_target <= '0;
    end else if (lk_fire) begin
      rsp_valid  <= 1'b1;
      rsp_hit    <= lk_hit;
      rsp_cold   <= (lk_kind == LK_COLD);
      rsp_taken  <= lk_hit && rd_ctr[1];
      rsp_target <= lk_hit ? rd_target : '0;
    end else if (rsp_ready) begin
      rsp_valid  <= 1'b0;
    end
  end

  btb_stats #(.CNT_W(CNT_W)) i_stats (
    .clk        (clk),
    .rst_n      (rst_n),
    .fire       (lk_fire),
    .kind       (lk_kind),
    .hit_count  (hit_count),
    .cold_count (cold_miss_count),
    .repl_count (repl_miss_count)
  );

  assert_stall_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_hit) && $stable(rsp_cold) &&
                                   $stable(rsp_taken) && $stable(rsp_target)));

  assert_idle_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> lk_ready);

  assert_miss_outputs_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (!rsp_taken && rsp_target == '0));

  assert_cold_is_miss_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_cold) |-> !rsp_hit);

  assert_lookup_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fire |=> rsp_valid);

  assert_flush_then_miss_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (task_switch && !upd_valid) ##1 lk_fire |=> (rsp_valid && !rsp_hit));

endmodule

// File: tb/test_branch_target_buffer.sv
module test_branch_target_buffer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lk_valid = 1'b0, lk_ready;
  logic [31:0] lk_pc = '0;
  logic        rsp_valid, rsp_ready = 1'b1;
  logic        rsp_hit, rsp_cold, rsp_taken;
  logic [31:0] rsp_target;
  logic        upd_valid = 1'b0;
  logic [31:0] upd_pc = '0, upd_target = '0;
  logic        upd_taken = 1'b0, upd_kill = 1'b0, task_switch = 1'b0;
  logic [15:0] hit_count, cold_miss_count, repl_miss_count;

  always #4 clk = ~clk;

  branch_target_buffer i_branch_target_buffer (
    .clk, .rst_n, .lk_valid, .lk_ready, .lk_pc, .rsp_valid, .rsp_ready,
    .rsp_hit, .rsp_cold, .rsp_taken, .rsp_target, .upd_valid, .upd_pc,
    .upd_target, .upd_taken, .upd_kill, .task_switch,
    .hit_count, .cold_miss_count, .repl_miss_count
  );

  int checks = 0, errors = 0;

  // reference model
  bit          m_live [64];
  bit          m_wr   [64];
  logic [23:0] m_tag  [64];
  logic [31:0] m_tgt  [64];
  logic [1:0]  m_ctr  [64];
  bit          e_rv = 0, e_hit = 0, e_cold = 0, e_tk = 0;
  logic [31:0] e_tgt = '0;
  int          n_hit = 0, n_cold = 0, n_repl = 0;

  function automatic logic [1:0] train(input logic [1:0] c, input bit tk);
    if (tk) return (c == 2'd3) ? c : c + 2'd1;
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  function automatic logic [31:0] mkpc(input logic [23:0] tg, input logic [5:0] ix);
    return {tg, ix, 2'b00};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic step(input bit lv, input logic [31:0] lpc,
                      input bit uv, input logic [31:0] upc, input logic [31:0] utg,
                      input bit utk, input bit uk, input bit ts, input bit rr,
                      input string req);
    bit exp_ready, fire, m;
    int i;
    lk_valid = lv; lk_pc = lpc; upd_valid = uv; upd_pc = upc; upd_target = utg;
    upd_taken = utk; upd_kill = uk; task_switch = ts; rsp_ready = rr;
    #1;
    exp_ready = !e_rv || rr;
    chk(lk_ready == exp_ready, "R11", "lk_ready", 32'(lk_ready), 32'(exp_ready));
    fire = lv && exp_ready;
    if (fire) begin
      i = lpc[7:2];
      e_hit  = m_live[i] && (m_tag[i] == lpc[31:8]);
      e_cold = !e_hit && !m_wr[i];
      e_tk   = e_hit && m_ctr[i][1];
      e_tgt  = e_hit ? m_tgt[i] : '0;
      e_rv   = 1;
      if (e_hit) n_hit++; else if (e_cold) n_cold++; else n_repl++;
    end else if (rr) begin
      e_rv = 0;
    end
    if (ts) foreach (m_live[k]) m_live[k] = 0;
    if (uv) begin
      i = upc[7:2];
      m = m_live[i] && (m_tag[i] == upc[31:8]);
      if (uk) begin
        if (m) m_live[i] = 0;
      end else if (m) begin
        m_tgt[i] = utg; m_ctr[i] = train(m_ctr[i], utk);
      end else begin
        m_live[i] = 1; m_wr[i] = 1; m_tag[i] = upc[31:8];
        m_tgt[i] = utg; m_ctr[i] = utk ? 2'd2 : 2'd1;
      end
    end
    @(negedge clk);
    chk(rsp_valid == e_rv, "R3", "rsp_valid", 32'(rsp_valid), 32'(e_rv));
    if (e_rv) begin
      chk(rsp_hit == e_hit, {req, "/R2"}, "rsp_hit", 32'(rsp_hit), 32'(e_hit));
      chk(rsp_cold == e_cold, {req, "/R9"}, "rsp_cold", 32'(rsp_cold), 32'(e_cold));
      chk(rsp_taken == e_tk, {req, "/R4"}, "rsp_taken", 32'(rsp_taken), 32'(e_tk));
      chk(rsp_target == e_tgt, {req, "/R4"}, "rsp_target", rsp_target, e_tgt);
    end
  endtask

  // lookup only
  task automatic look(input logic [31:0] pc, input string req);
    step(1, pc, 0, '0, '0, 0, 0, 0, 1, req);
  endtask

  // update only
  task automatic upd(input logic [31:0] pc, input logic [31:0] tg, input bit tk,
                     input bit kill);
    step(0, '0, 1, pc, tg, tk, kill, 0, 1, "upd");
  endtask

  task automatic chk_counts(input string req);
    chk(hit_count == 16'(n_hit), req, "hit_count", 32'(hit_count), 32'(n_hit));
    chk(cold_miss_count == 16'(n_cold), req, "cold_miss_count",
        32'(cold_miss_count), 32'(n_cold));
    chk(repl_miss_count == 16'(n_repl), req, "repl_miss_count",
        32'(repl_miss_count), 32'(n_repl));
  endtask

  initial begin : watchdog
    #1600000;
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    foreach (m_live[k]) begin m_live[k] = 0; m_wr[k] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(rsp_valid == 1'b0, "R1", "rsp_valid", 32'(rsp_valid), 0);
    chk(lk_ready == 1'b1, "R1", "lk_ready", 32'(lk_ready), 1);
    chk_counts("R1");
    @(negedge clk);

    // R1/R9 first lookups are cold
    look(mkpc(24'h000111, 6'd5), "R1");
    look(mkpc(24'h000111, 6'd63), "R1");

    // R5 allocate, R2 hit and tag mismatch, R4 fields
    upd(mkpc(24'h000111, 6'd5), 32'h0000_4000, 1, 0);
    look(mkpc(24'h000111, 6'd5), "R5");
    look(mkpc(24'h000222, 6'd5), "R2");       // replacement miss, other tag
    look(mkpc(24'h000111, 6'd6), "R2");       // other slot, cold

    // R6 saturation up and down
    for (int n = 0; n < 4; n++) begin
      upd(mkpc(24'h000111, 6'd5), 32'h0000_5000 + 32'(n), 1, 0);
      look(mkpc(24'h000111, 6'd5), "R6");
    end
    for (int n = 0; n < 5; n++) begin
      upd(mkpc(24'h000111, 6'd5), 32'h0000_6000, 0, 0);
      look(mkpc(24'h000111, 6'd5), "R6");
    end

    // R5 replacement by other tag, not-taken seed
    upd(mkpc(24'h000333, 6'd5), 32'h0000_7000, 0, 0);
    look(mkpc(24'h000111, 6'd5), "R5");
    look(mkpc(24'h000333, 6'd5), "R5");

    // R7 kill with wrong tag ignored, then matching kill
    upd(mkpc(24'h000444, 6'd5), '0, 0, 1);
    look(mkpc(24'h000333, 6'd5), "R7");
    upd(mkpc(24'h000333, 6'd5), '0, 0, 1);
    look(mkpc(24'h000333, 6'd5), "R7");       // replacement miss after kill

    // R3 lookup in same cycle as update to same slot sees old contents
    step(1, mkpc(24'h000555, 6'd9), 1, mkpc(24'h000555, 6'd9), 32'h0000_8000, 1, 0, 0, 1, "R3");
    look(mkpc(24'h000555, 6'd9), "R3");

    // R8 task switch flushes; same-cycle update allocates afterwards
    upd(mkpc(24'h000666, 6'd12), 32'h0000_9000, 1, 0);
    step(0, '0, 0, '0, '0, 0, 0, 1, 1, "R8");
    look(mkpc(24'h000555, 6'd9), "R8");
    look(mkpc(24'h000666, 6'd12), "R8");
    upd(mkpc(24'h000777, 6'd20), 32'h0000_A000, 1, 0);
    step(0, '0, 1, mkpc(24'h000777, 6'd20), 32'h0000_B000, 0, 0, 1, 1, "R8");
    look(mkpc(24'h000777, 6'd20), "R8");      // fresh allocation, counter 1

    // R11 stall holds response, then drain
    step(1, mkpc(24'h000777, 6'd20), 0, '0, '0, 0, 0, 0, 0, "R11");
    step(1, mkpc(24'h000111, 6'd30), 0, '0, '0, 0, 0, 0, 0, "R11");
    step(1, mkpc(24'h000111, 6'd30), 0, '0, '0, 0, 0, 0, 1, "R11");
    step(0, '0, 0, '0, '0, 0, 0, 0, 1, "R11");
    chk_counts("R10");

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [23:0] lt, ut;
      logic [5:0]  li, ui;
      lt = 24'h0A0000 | 24'($urandom_range(0, 3));
      ut = 24'h0A0000 | 24'($urandom_range(0, 3));
      li = 6'($urandom_range(0, 15));
      ui = 6'($urandom_range(0, 15));
      step($urandom_range(0, 3) != 0, mkpc(lt, li),
           $urandom_range(0, 1) != 0, mkpc(ut, ui), $urandom,
           $urandom_range(0, 1) != 0, $urandom_range(0, 7) == 0,
           $urandom_range(0, 63) == 0, $urandom_range(0, 7) != 0, "rand");
    end
    step(0, '0, 0, '0, '0, 0, 0, 0, 1, "R11");
    chk_counts("R10");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule